// File: doc/BRIEF.md
# TDM Sense Data Slot Transmitter

This block sends up to five monitor streams on a shared TDM output line. The streams are current sense, voltage sense, supply voltage, die temperature and limiter gain. The output is organised in 8-bit slot units. Each stream has its own enable and a 6-bit starting slot number, which marks where its most significant bit goes out. A stream fills one, two or three consecutive slots, depending on the stream and on its length setting.

The block runs from a fast system clock. It samples the bit clock and the frame sync as plain synchronous levels. One control bit selects which bit-clock edge launches data; the opposite edge samples the frame sync. A frame starts when the sampled frame sync rises. A 3-bit offset places slot 0 a few bit clocks after the frame start. The sample words are captured at each frame start, so every stream stays constant for the whole frame. The output is a data bit plus an output enable, which lets several transmitters share one tri-state line. Bit positions that no enabled stream covers are either driven low or released, depending on a fill control.

When enabled fields overlap, a fixed priority decides which stream drives the line. Bits that would fall after the next frame start are never sent, because a new frame restarts the bit count.

Top module: `tdm_sense_tx`

## Requirements
- R1: After a frame start, the Nth launch edge (counting from 0) sends frame bit N. Slot k covers frame bits offset+8k to offset+8k+7, MSB first, for any offset from 0 to 7.
- R2: With launch_fall=1, sd_out and sd_oe change only after falling bit-clock edges, and fsync is sampled on rising edges. With launch_fall=0 the two edges swap roles.
- R3: Temperature and gain each send their 8-bit word in the single slot given by their slot number, MSB first.
- R4: With sup_wide=0, the supply stream sends the upper 8 of its 10 bits in one slot. With sup_wide=1, it sends all 10 bits followed by six zero bits across two slots.
- R5: iv_len sets the current and voltage field length. Code 00 sends all 16 bits over two slots. Code 10 sends the upper 8 bits in one slot. The reserved code 11 behaves as 00.
- R6: With iv_len=01, current and voltage each send their upper 12 bits. If both are enabled and one slot number is exactly one above the other, the higher-slot stream starts 12 bits after the lower-slot stream's start, so the pair fills three slots. Otherwise each stream starts at its own slot.
- R7: A stream whose enable is low sends nothing. Its positions behave as uncovered.
- R8: On a covered position, sd_oe is 1. On an uncovered position, fill_hiz=1 gives sd_oe=0, and fill_hiz=0 gives sd_oe=1 with sd_out=0. Whenever sd_oe is 0, sd_out is 0.
- R9: A new frame start restarts the bit count. Bits of a field that reach past the next frame start are never sent, and the field does not resume in the next frame.
- R10: Where enabled fields overlap, the bit comes from the highest-priority stream. The order, from highest, is current, voltage, supply, temperature, gain.
- R11: Sample words are captured at the frame start. Changes to them during a frame show up only from the next frame.
- R12: After reset, and until the first frame start, sd_oe and sd_out stay 0 whatever the bit clock does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock level, synchronous to clk |
| fsync | input | 1 | Frame sync level, synchronous to clk |
| launch_fall | input | 1 | 1: launch on falling bit-clock edge; 0: launch on rising |
| slot_offset | input | OFFSET_W | Bit clocks from frame start to slot 0 |
| fill_hiz | input | 1 | 1: release uncovered positions; 0: drive them low |
| iv_len | input | 2 | Current/voltage length code |
| sup_wide | input | 1 | 1: supply sent as 16-bit field; 0: upper 8 bits |
| cur_en | input | 1 | Current stream enable |
| cur_slot | input | SLOT_ID_W | Current stream start slot |
| cur_word | input | IV_W | Current sample |
| volt_en | input | 1 | Voltage stream enable |
| volt_slot | input | SLOT_ID_W | Voltage stream start slot |
| volt_word | input | IV_W | Voltage sample |
| sup_en | input | 1 | Supply stream enable |
| sup_slot | input | SLOT_ID_W | Supply stream start slot |
| sup_word | input | SUP_W | Supply sample |
| temp_en | input | 1 | Temperature stream enable |
| temp_slot | input | SLOT_ID_W | Temperature stream start slot |
| temp_word | input | SM_W | Temperature sample |
| gain_en | input | 1 | Gain stream enable |
| gain_slot | input | SLOT_ID_W | Gain stream start slot |
| gain_word | input | SM_W | Gain sample |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for the shared line |

## Verification
The bench builds the block with its default parameters: 6-bit slot numbers, a 3-bit offset and 8-bit slots. With these values the last slot (63) and the largest offset (7) can both be reached. One directed frame of 520 bit clocks places a wide supply field at slot 63, so that it straddles the frame end. Random frames keep their slots in the lower sixteen so that frames stay short. Those frames still produce packed pairs, overlaps and fields cut by short frames. The directed cases cover both launch edges, every length code and both orders of a packed pair.

// File: rtl/tdm_sense_pkg.sv
package tdm_sense_pkg;

  localparam int NSTREAM = 5;

  // Stream index doubles as priority rank: lower index wins on overlap.
  localparam int S_CUR  = 0;
  localparam int S_VOLT = 1;
  localparam int S_SUP  = 2;
  localparam int S_TEMP = 3;
  localparam int S_GAIN = 4;

  typedef enum logic [1:0] {
    IVL_FULL = 2'b00,
    IVL_PACK = 2'b01,
    IVL_HALF = 2'b10,
    IVL_RSVD = 2'b11
  } iv_len_e;

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             launch_fall,
  output logic             launch,
  output logic             frame_start,
  output logic             frame_live,
  output logic [CNT_W-1:0] bit_idx
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic bclk_q;
  logic fs_cap;
  logic rise, fall, capture;

  assign rise    = bclk & ~bclk_q;
  assign fall    = ~bclk & bclk_q;
  assign launch  = launch_fall ? fall : rise;
  assign capture = launch_fall ? rise : fall;

  assign frame_start = capture & fsync & ~fs_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q     <= 1'b0;
      fs_cap     <= 1'b0;
      frame_live <= 1'b0;
      bit_idx    <= '0;
    end else begin
      bclk_q <= bclk;
      if (capture) fs_cap <= fsync;
      if (frame_start) begin
        frame_live <= 1'b1;
        bit_idx    <= '0;
      end else if (launch && frame_live && bit_idx != CNT_MAX) begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R9: a frame start always rewinds the position to the first bit
  p_rewind_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (bit_idx == '0) && frame_live);

endmodule

// File: rtl/tdm_word_latch.sv
module tdm_word_latch #(
  parameter int NW = 5,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NW-1:0][FW-1:0] word_in,
  output logic [NW-1:0][FW-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= word_in;
  end

  // R11: captured words hold for the whole frame
  p_hold_frame_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(word_q));

endmodule

// File: rtl/tdm_field_map.sv
module tdm_field_map
  import tdm_sense_pkg::*;
#(
  parameter int SLOT_ID_W = 6,
  parameter int OFFSET_W  = 3,
  parameter int SLOT_BITS = 8,
  parameter int FW        = 16,
  parameter int CNT_W     = 10
) (
  input  logic [CNT_W-1:0]                    bit_idx,
  input  logic [OFFSET_W-1:0]                 slot_offset,
  input  logic [1:0]                          iv_len,
  input  logic                                sup_wide,
  input  logic [NSTREAM-1:0]                  en_v,
  input  logic [NSTREAM-1:0][SLOT_ID_W-1:0]   slot_v,
  input  logic [NSTREAM-1:0][FW-1:0]          word_v,
  output logic                                hit,
  output logic                                bit_val
);

  localparam int LEN_W    = $clog2(FW + 1);
  localparam int PK_LEN   = (3 * FW) / 4;
  localparam int HALF_LEN = FW / 2;

  logic [CNT_W-1:0]                 rel;
  logic                             rel_ok;
  logic [NSTREAM-1:0][CNT_W-1:0]    base_v;
  logic [NSTREAM-1:0][CNT_W-1:0]    start_v;
  logic [NSTREAM-1:0][LEN_W-1:0]    len_v;
  logic [NSTREAM-1:0]               hit_v;
  logic [NSTREAM-1:0]               val_v;
  logic [LEN_W-1:0]                 iv_bits;
  logic                             cur_after_volt;
  logic                             volt_after_cur;
  logic                             pack_pair;

  assign rel_ok = bit_idx >= CNT_W'(slot_offset);
  assign rel    = bit_idx - CNT_W'(slot_offset);

  always_comb begin
    unique case (iv_len_e'(iv_len))
      IVL_PACK: iv_bits = LEN_W'(PK_LEN);
      IVL_HALF: iv_bits = LEN_W'(HALF_LEN);
      IVL_FULL: iv_bits = LEN_W'(FW);
      IVL_RSVD: iv_bits = LEN_W'(FW);
      default:  iv_bits = LEN_W'(FW);
    endcase
  end

  always_comb begin
    len_v         = '0;
    len_v[S_CUR]  = iv_bits;
    len_v[S_VOLT] = iv_bits;
    len_v[S_SUP]  = sup_wide ? LEN_W'(FW) : LEN_W'(SLOT_BITS);
    len_v[S_TEMP] = LEN_W'(SLOT_BITS);
    len_v[S_GAIN] = LEN_W'(SLOT_BITS);
  end

  genvar s;
  generate
    for (s = 0; s < NSTREAM; s++) begin : g_base
      assign base_v[s] = CNT_W'(slot_v[s]) * CNT_W'(SLOT_BITS);
    end
  endgenerate

  assign cur_after_volt = CNT_W'(slot_v[S_CUR])  == CNT_W'(slot_v[S_VOLT]) + CNT_W'(1);
  assign volt_after_cur = CNT_W'(slot_v[S_VOLT]) == CNT_W'(slot_v[S_CUR])  + CNT_W'(1);
  assign pack_pair      = (iv_len_e'(iv_len) == IVL_PACK) && en_v[S_CUR] && en_v[S_VOLT];

  // In packed mode the second stream of an adjacent pair slides up by one
  // packed field so the two fields share the middle slot.
  always_comb begin
    start_v = base_v;
    if (pack_pair && cur_after_volt)
      start_v[S_CUR] = base_v[S_VOLT] + CNT_W'(PK_LEN);
    if (pack_pair && volt_after_cur)
      start_v[S_VOLT] = base_v[S_CUR] + CNT_W'(PK_LEN);
  end

  generate
    for (s = 0; s < NSTREAM; s++) begin : g_field
      logic [CNT_W-1:0] pos;
      logic [CNT_W-1:0] stop;
      logic [FW-1:0]    shifted;
      assign pos      = rel - start_v[s];
      assign stop     = start_v[s] + CNT_W'(len_v[s]);
      assign shifted  = word_v[s] << pos;
      assign hit_v[s] = en_v[s] && rel_ok && (rel >= start_v[s]) && (rel < stop);
      assign val_v[s] = shifted[FW-1];
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    bit_val = 1'b0;
    for (int k = NSTREAM - 1; k >= 0; k--) begin
      if (hit_v[k]) begin
        hit     = 1'b1;
        bit_val = val_v[k];
      end
    end
  end

endmodule

// File: rtl/tdm_out_stage.sv
module tdm_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic frame_live,
  input  logic hit,
  input  logic bit_val,
  input  logic fill_hiz,
  output logic sd_out,
  output logic sd_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (launch) begin
      if (!frame_live) begin
        sd_out <= 1'b0;
        sd_oe  <= 1'b0;
      end else if (hit) begin
        sd_out <= bit_val;
        sd_oe  <= 1'b1;
      end else begin
        sd_out <= 1'b0;
        sd_oe  <= ~fill_hiz;
      end
    end
  end

  // R2: line changes only in the cycle after a launch edge
  p_hold_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(launch) |-> ($stable(sd_out) && $stable(sd_oe)));

  // R8: low fill keeps the line driven for every launched bit
  p_fill_drive_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(launch) && $past(frame_live) && !$past(fill_hiz)) |-> sd_oe);

  // R8: released line carries no data
  p_quiet_data_r8: assert property (@(posedge clk) disable iff (rst)
    !sd_oe |-> !sd_out);

  // R12: nothing is driven before the first frame
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !frame_live |-> !sd_oe);

endmodule

// File: rtl/tdm_sense_tx.sv
module tdm_sense_tx
  import tdm_sense_pkg::*;
#(
  parameter int SLOT_ID_W = 6,
  parameter int OFFSET_W  = 3,
  parameter int SLOT_BITS = 8,
  parameter int IV_W      = 16,
  parameter int SUP_W     = 10,
  parameter int SM_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk,
  input  logic                 fsync,
  input  logic                 launch_fall,
  input  logic [OFFSET_W-1:0]  slot_offset,
  input  logic                 fill_hiz,
  input  logic [1:0]           iv_len,
  input  logic                 sup_wide,
  input  logic                 cur_en,
  input  logic [SLOT_ID_W-1:0] cur_slot,
  input  logic [IV_W-1:0]      cur_word,
  input  logic                 volt_en,
  input  logic [SLOT_ID_W-1:0] volt_slot,
  input  logic [IV_W-1:0]      volt_word,
  input  logic                 sup_en,
  input  logic [SLOT_ID_W-1:0] sup_slot,
  input  logic [SUP_W-1:0]     sup_word,
  input  logic                 temp_en,
  input  logic [SLOT_ID_W-1:0] temp_slot,
  input  logic [SM_W-1:0]      temp_word,
  input  logic                 gain_en,
  input  logic [SLOT_ID_W-1:0] gain_slot,
  input  logic [SM_W-1:0]      gain_word,
  output logic                 sd_out,
  output logic                 sd_oe
);

  localparam int FW    = IV_W;
  localparam int CNT_W = $clog2((1 << OFFSET_W) + (1 << SLOT_ID_W) * SLOT_BITS + 2 * FW + 1);

  logic                              launch;
  logic                              frame_start;
  logic                              frame_live;
  logic [CNT_W-1:0]                  bit_idx;
  logic [NSTREAM-1:0]                en_v;
  logic [NSTREAM-1:0][SLOT_ID_W-1:0] slot_v;
  logic [NSTREAM-1:0][FW-1:0]        word_in;
  logic [NSTREAM-1:0][FW-1:0]        word_q;
  logic                              hit;
  logic                              bit_val;

  always_comb begin
    en_v           = '0;
    slot_v         = '0;
    word_in        = '0;
    en_v[S_CUR]    = cur_en;
    en_v[S_VOLT]   = volt_en;
    en_v[S_SUP]    = sup_en;
    en_v[S_TEMP]   = temp_en;
    en_v[S_GAIN]   = gain_en;
    slot_v[S_CUR]  = cur_slot;
    slot_v[S_VOLT] = volt_slot;
    slot_v[S_SUP]  = sup_slot;
    slot_v[S_TEMP] = temp_slot;
    slot_v[S_GAIN] = gain_slot;
    // every word left-justified in a common field width
    word_in[S_CUR]  = cur_word;
    word_in[S_VOLT] = volt_word;
    word_in[S_SUP]  = {sup_word,  {(FW - SUP_W){1'b0}}};
    word_in[S_TEMP] = {temp_word, {(FW - SM_W){1'b0}}};
    word_in[S_GAIN] = {gain_word, {(FW - SM_W){1'b0}}};
  end

  tdm_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .bclk        (bclk),
    .fsync       (fsync),
    .launch_fall (launch_fall),
    .launch      (launch),
    .frame_start (frame_start),
    .frame_live  (frame_live),
    .bit_idx     (bit_idx)
  );

  tdm_word_latch #(.NW(NSTREAM), .FW(FW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load    (frame_start),
    .word_in (word_in),
    .word_q  (word_q)
  );

  tdm_field_map #(
    .SLOT_ID_W (SLOT_ID_W),
    .OFFSET_W  (OFFSET_W),
    .SLOT_BITS (SLOT_BITS),
    .FW        (FW),
    .CNT_W     (CNT_W)
  ) u_map (
    .bit_idx     (bit_idx),
    .slot_offset (slot_offset),
    .iv_len      (iv_len),
    .sup_wide    (sup_wide),
    .en_v        (en_v),
    .slot_v      (slot_v),
    .word_v      (word_q),
    .hit         (hit),
    .bit_val     (bit_val)
  );

  tdm_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .frame_live (frame_live),
    .hit        (hit),
    .bit_val    (bit_val),
    .fill_hiz   (fill_hiz),
    .sd_out     (sd_out),
    .sd_oe      (sd_oe)
  );

endmodule

// File: tb/tb_tdm_sense_tx.sv
module tb_tdm_sense_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       bclk = 1'b0, fsync = 1'b0, launch_fall = 1'b1;
  logic [2:0] slot_offset = 3'd1;
  logic       fill_hiz = 1'b1, sup_wide = 1'b0;
  logic [1:0] iv_len = 2'd0;
  logic       cur_en = 0, volt_en = 0, sup_en = 0, temp_en = 0, gain_en = 0;
  logic [5:0] cur_slot = 6'd0, volt_slot = 6'd2, sup_slot = 6'd4, temp_slot = 6'd5, gain_slot = 6'd6;
  logic [15:0] cur_word = 0, volt_word = 0;
  logic [9:0]  sup_word = 0;
  logic [7:0]  temp_word = 0, gain_word = 0;
  logic        sd_out, sd_oe;

  logic [15:0] s_cur, s_volt;
  logic [9:0]  s_sup;
  logic [7:0]  s_temp, s_gain;
  logic        last_oe, last_d;

  int checks = 0;
  int errors = 0;

  tdm_sense_tx dut (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .launch_fall(launch_fall),
    .slot_offset(slot_offset), .fill_hiz(fill_hiz), .iv_len(iv_len), .sup_wide(sup_wide),
    .cur_en(cur_en), .cur_slot(cur_slot), .cur_word(cur_word),
    .volt_en(volt_en), .volt_slot(volt_slot), .volt_word(volt_word),
    .sup_en(sup_en), .sup_slot(sup_slot), .sup_word(sup_word),
    .temp_en(temp_en), .temp_slot(temp_slot), .temp_word(temp_word),
    .gain_en(gain_en), .gain_slot(gain_slot), .gain_word(gain_word),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Reference model built from the requirements (R1, R3-R8, R10).
  function automatic void model(input int n, output logic e_oe, output logic e_d, output string fld);
    int p; int ivl;
    int st[5]; int ln[5]; logic [15:0] w[5]; logic en[5]; string nm[5];
    p = n - int'(slot_offset);
    case (iv_len)
      2'd1: ivl = 12;
      2'd2: ivl = 8;
      default: ivl = 16;
    endcase
    st[0] = int'(cur_slot) * 8;  st[1] = int'(volt_slot) * 8; st[2] = int'(sup_slot) * 8;
    st[3] = int'(temp_slot) * 8; st[4] = int'(gain_slot) * 8;
    if (iv_len == 2'd1 && cur_en && volt_en) begin
      if (int'(cur_slot) == int'(volt_slot) + 1) st[0] = int'(volt_slot) * 8 + 12;
      if (int'(volt_slot) == int'(cur_slot) + 1) st[1] = int'(cur_slot) * 8 + 12;
    end
    ln[0] = ivl; ln[1] = ivl; ln[2] = sup_wide ? 16 : 8; ln[3] = 8; ln[4] = 8;
    w[0] = s_cur; w[1] = s_volt; w[2] = {s_sup, 6'b0}; w[3] = {s_temp, 8'b0}; w[4] = {s_gain, 8'b0};
    en[0] = cur_en; en[1] = volt_en; en[2] = sup_en; en[3] = temp_en; en[4] = gain_en;
    nm[0] = (iv_len == 2'd1) ? "R6" : "R5"; nm[1] = nm[0];
    nm[2] = "R4"; nm[3] = "R3"; nm[4] = "R3";
    e_oe = !fill_hiz; e_d = 1'b0; fld = "R8";
    for (int s = 4; s >= 0; s--) begin
      if (en[s] && p >= st[s] && p < st[s] + ln[s]) begin
        e_oe = 1'b1; e_d = w[s][15 - (p - st[s])]; fld = nm[s];
      end
    end
  endfunction

  task automatic check(input string tag, input string fld, input int n,
                       input logic exp_oe, input logic exp_d);
    checks++;
    if (sd_oe !== exp_oe || sd_out !== exp_d) begin
      errors++;
      $display("FAIL %s (%s) bit %0d: got oe=%b d=%b expected oe=%b d=%b",
               tag, fld, n, sd_oe, sd_out, exp_oe, exp_d);
    end
  endtask

  task automatic drive_edge(input logic lvl);
    @(negedge clk);
    bclk = lvl;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic cap_lvl();
    return launch_fall ? 1'b1 : 1'b0;
  endfunction

  task automatic new_words();
    cur_word  = 16'($urandom);
    volt_word = 16'($urandom);
    sup_word  = 10'($urandom);
    temp_word = 8'($urandom);
    gain_word = 8'($urandom);
  endtask

  task automatic all_off();
    cur_en = 0; volt_en = 0; sup_en = 0; temp_en = 0; gain_en = 0;
  endtask

  // One frame of nbits launched bits; samples are changed mid-frame (R11).
  task automatic run_frame(input string tag, input int nbits);
    logic e_oe, e_d; string fld;
    s_cur = cur_word; s_volt = volt_word; s_sup = sup_word; s_temp = temp_word; s_gain = gain_word;
    fsync = 1'b1;
    drive_edge(cap_lvl());
    for (int b = 0; b < nbits; b++) begin
      if (b > 0) begin
        drive_edge(cap_lvl());
        checks++;   // R2: capture edge leaves the line alone
        if (sd_oe !== last_oe || sd_out !== last_d) begin
          errors++;
          $display("FAIL R2 capture edge before bit %0d: got oe=%b d=%b expected oe=%b d=%b",
                   b, sd_oe, sd_out, last_oe, last_d);
        end
      end
      drive_edge(~cap_lvl());
      if (b == 0) fsync = 1'b0;
      if (b == 3) new_words();
      model(b, e_oe, e_d, fld);
      check(tag, fld, b, e_oe, e_d);
      last_oe = sd_oe; last_d = sd_out;
    end
  endtask

  task automatic set_launch(input logic v);
    launch_fall = v;
    drive_edge(v ? 1'b0 : 1'b1);
  endtask

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'h1357));
    last_oe = 0; last_d = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R12: idle before any frame, even with fill low and a stream enabled
    fill_hiz = 0; cur_en = 1; new_words();
    for (int k = 0; k < 6; k++) begin
      drive_edge(~bclk);
      check("R12", "idle", k, 1'b0, 1'b0);
    end

    // R3: temperature and gain single slots, low fill
    all_off(); temp_en = 1; gain_en = 1; slot_offset = 3'd1;
    run_frame("R3", 64);

    // R1: offsets 0 and 7, full current field
    all_off(); cur_en = 1; cur_slot = 6'd0; iv_len = 2'd0;
    slot_offset = 3'd0; run_frame("R1", 32);
    slot_offset = 3'd7; cur_slot = 6'd1; run_frame("R1", 40);

    // R4: supply narrow and wide, released fill
    all_off(); fill_hiz = 1; sup_en = 1; sup_slot = 6'd2; slot_offset = 3'd1;
    sup_wide = 0; run_frame("R4", 48);
    sup_wide = 1; run_frame("R4", 48);

    // R5: length codes 00, 10, 11
    all_off(); cur_en = 1; volt_en = 1; cur_slot = 6'd0; volt_slot = 6'd2; fill_hiz = 0;
    iv_len = 2'd0; run_frame("R5", 48);
    iv_len = 2'd2; run_frame("R5", 48);
    iv_len = 2'd3; run_frame("R5", 48);

    // R6: packed pair both orders, and with one partner disabled
    iv_len = 2'd1; cur_slot = 6'd2; volt_slot = 6'd3; run_frame("R6", 48);
    cur_slot = 6'd4; volt_slot = 6'd3; run_frame("R6", 56);
    volt_en = 0; run_frame("R6", 56);

    // R7: enables low, both fills
    all_off(); fill_hiz = 0; run_frame("R7", 24);
    fill_hiz = 1; run_frame("R7", 24);

    // R10: overlapping fields
    all_off(); iv_len = 2'd0; fill_hiz = 0;
    cur_en = 1; volt_en = 1; sup_en = 1; temp_en = 1; gain_en = 1;
    cur_slot = 6'd1; volt_slot = 6'd0; sup_slot = 6'd2; sup_wide = 1;
    temp_slot = 6'd3; gain_slot = 6'd3; run_frame("R10", 48);

    // R9: wide supply at slot 63 straddles a 520-bit frame, then short frames
    all_off(); sup_en = 1; sup_slot = 6'd63; sup_wide = 1; slot_offset = 3'd7; fill_hiz = 0;
    run_frame("R9", 520);
    volt_en = 1; volt_slot = 6'd2; slot_offset = 3'd0;
    run_frame("R9", 20);
    run_frame("R9", 32);

    // R2: rising-edge launch, then back to falling
    set_launch(1'b0);
    all_off(); cur_en = 1; cur_slot = 6'd1; gain_en = 1; gain_slot = 6'd0; slot_offset = 3'd1;
    run_frame("R2", 40);
    set_launch(1'b1);
    run_frame("R2", 40);

    // R11 plus random mixes of everything above
    for (int f = 0; f < 12; f++) begin
      slot_offset = 3'($urandom_range(0, 7));
      fill_hiz = 1'($urandom_range(0, 1));
      iv_len   = 2'($urandom_range(0, 3));
      sup_wide = 1'($urandom_range(0, 1));
      cur_en = 1'($urandom_range(0, 1)); volt_en = 1'($urandom_range(0, 1));
      sup_en = 1'($urandom_range(0, 1)); temp_en = 1'($urandom_range(0, 1));
      gain_en = 1'($urandom_range(0, 1));
      cur_slot = 6'($urandom_range(0, 15)); volt_slot = 6'($urandom_range(0, 15));
      sup_slot = 6'($urandom_range(0, 15)); temp_slot = 6'($urandom_range(0, 15));
      gain_slot = 6'($urandom_range(0, 15));
      if (f % 3 == 0) begin iv_len = 2'd1; cur_en = 1; volt_en = 1; volt_slot = cur_slot + 6'd1; end
      new_words();
      run_frame("R11", $urandom_range(64, 160));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule